// File: doc/BRIEF.md
# Bit-Serial Running Maximum Tracker

This block finds the largest of a fixed-length run of unsigned words. Each word arrives one bit per accepted clock, most significant bit first. The block reports the largest value together with the zero-based position of that word in the run. A one-cycle start pulse opens a run. A strobe marks each clock that carries a data bit, so idle clocks may fall anywhere inside a word or between words.

There is no parallel magnitude comparator. A three-state order machine (equal, greater, less) looks at one incoming bit and one stored bit per clock. The stored maximum rotates in step with the arriving bits, so the two bits being compared always have the same weight. A shift register rebuilds the incoming word. The maximum register loads that word, and the index register loads the word counter, only when the order machine ends the word in its greater state. When the last bit of the last word has been taken, a done flag rises and the results stay on the outputs until the next start.

Top module: `serial_max_tracker`

## Requirements
- R1: A start pulse clears the maximum to zero, the index to zero and the done flag, and opens a new run. The outputs show these cleared values on the clock after the pulse.
- R2: A run holds NUM_WORDS words (default 16) of WORD_W bits each (default 8). Each word is sent most significant bit first, one bit on each clock edge at which bit_vld_i is high.
- R3: When done_o is high, max_o holds the largest unsigned word of the run.
- R4: When done_o is high, idx_o holds the zero-based position in the run of the word reported on max_o.
- R5: When two or more words are equal to the maximum, idx_o reports the earliest of them. A later word that only equals the stored maximum does not replace it.
- R6: When every word in the run is zero, max_o is zero and idx_o is zero.
- R7: done_o is low while the final bit of word NUM_WORDS-1 is pending. It is high on the clock after the edge that takes that bit, and it stays high until the next start pulse or reset.
- R8: Clocks with bit_vld_i low have no effect, whatever the value of bit_i. Idle clocks may fall between any two bits of a word.
- R9: Once done_o is high, further valid bits change neither max_o, idx_o nor done_o.
- R10: A start pulse in the middle of a run drops that run's partial result. The new run is evaluated from its first word.
- R11: A synchronous active-high reset clears the outputs and leaves no run open. Valid bits received before the first start pulse are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that opens a new run |
| bit_i | input | 1 | Serial data bit, most significant bit of each word first |
| bit_vld_i | input | 1 | High on clocks where bit_i carries a data bit |
| max_o | output | WORD_W | Largest word of the run, valid while done_o is high |
| idx_o | output | $clog2(NUM_WORDS) | Position of the largest word, valid while done_o is high |
| done_o | output | 1 | High once the whole run has been taken |

## Verification
The checker assumes that start_i, bit_vld_i and bit_i come from logic clocked on the same edge. It also assumes that the environment never holds start_i high across the clock where it expects the outputs to stay frozen. The properties therefore tie changes on idx_o and done_o to a valid bit or a start pulse sampled one clock earlier. The bench changes every input on the falling edge. It sends start only as single-clock pulses, either between runs or once on purpose in mid-run. During idle clocks it drives bit_i to the inverse of the pending bit, so a design that ignored the strobe would produce a wrong result.

// File: rtl/smax_pkg.sv
package smax_pkg;

    // Result of comparing the incoming word against the stored maximum so far
    typedef enum logic [1:0] {
        ORD_EQ = 2'd0,
        ORD_GT = 2'd1,
        ORD_LT = 2'd2
    } order_e;

    // Per-clock control produced by the sequencer
    typedef struct packed {
        logic take;      // a data bit is accepted on this edge
        logic word_end;  // that bit is the least significant bit of a word
        logic run_end;   // that word is the last one of the run
    } step_t;

    // One step of the bit-serial comparison: the first differing bit decides
    function automatic order_e order_step(order_e cur, logic in_b, logic ref_b);
        if (cur != ORD_EQ) return cur;
        if (in_b == ref_b) return ORD_EQ;
        return in_b ? ORD_GT : ORD_LT;
    endfunction

endpackage

// File: rtl/smax_seq.sv
module smax_seq
    import smax_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int NUM_WORDS = 16,
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             bit_vld_i,
    output step_t            step_o,
    output logic [IDX_W-1:0] word_idx_o,
    output logic             done_o
);

    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(NUM_WORDS - 1);

    logic             busy_q;
    logic             done_q;
    logic [BIT_W-1:0] bit_cnt_q;
    logic [IDX_W-1:0] word_cnt_q;
    step_t            step;

    always_comb begin
        step.take     = busy_q & bit_vld_i & ~start_i;
        step.word_end = step.take & (bit_cnt_q == LAST_BIT);
        step.run_end  = step.word_end & (word_cnt_q == LAST_WORD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            bit_cnt_q  <= '0;
            word_cnt_q <= '0;
        end else if (start_i) begin
            busy_q     <= 1'b1;
            done_q     <= 1'b0;
            bit_cnt_q  <= '0;
            word_cnt_q <= '0;
        end else if (step.take) begin
            bit_cnt_q <= step.word_end ? '0 : bit_cnt_q + 1'b1;
            if (step.word_end)
                word_cnt_q <= step.run_end ? '0 : word_cnt_q + 1'b1;
            if (step.run_end) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    assign step_o     = step;
    assign word_idx_o = word_cnt_q;
    assign done_o     = done_q;

endmodule

// File: rtl/smax_cmp.sv
module smax_cmp
    import smax_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear_i,
    input  step_t step_i,
    input  logic  in_b,
    input  logic  ref_b,
    output logic  win_o
);

    order_e state_q;
    order_e state_d;

    assign state_d = order_step(state_q, in_b, ref_b);
    // Load only on strict greater: ties keep the earlier word
    assign win_o   = step_i.word_end & (state_d == ORD_GT);

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            state_q <= ORD_EQ;
        else if (step_i.take)
            state_q <= step_i.word_end ? ORD_EQ : state_d;
    end

endmodule

// File: rtl/smax_store.sv
module smax_store
    import smax_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int NUM_WORDS = 16,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  step_t             step_i,
    input  logic              win_i,
    input  logic              in_b,
    input  logic [IDX_W-1:0]  word_idx_i,
    output logic              ref_b_o,
    output logic [WORD_W-1:0] max_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic [WORD_W-2:0] shift_q;   // bits of the current word received so far
    logic [WORD_W-1:0] word_in;   // full word once the final bit is present
    logic [WORD_W-1:0] max_q;     // rotates during a word, realigned at its end
    logic [IDX_W-1:0]  idx_q;

    assign word_in = {shift_q, in_b};
    assign ref_b_o = max_q[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            shift_q <= '0;
            max_q   <= '0;
            idx_q   <= '0;
        end else if (step_i.take) begin
            shift_q <= word_in[WORD_W-2:0];
            if (win_i) begin
                max_q <= word_in;
                idx_q <= word_idx_i;
            end else begin
                max_q <= {max_q[WORD_W-2:0], max_q[WORD_W-1]};
            end
        end
    end

    assign max_o = max_q;
    assign idx_o = idx_q;

endmodule

// File: rtl/serial_max_tracker.sv
module serial_max_tracker
    import smax_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int NUM_WORDS = 16,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              bit_i,
    input  logic              bit_vld_i,
    output logic [WORD_W-1:0] max_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              done_o
);

    step_t            step;
    logic [IDX_W-1:0] word_idx;
    logic             ref_b;
    logic             win;

    smax_seq #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .bit_vld_i  (bit_vld_i),
        .step_o     (step),
        .word_idx_o (word_idx),
        .done_o     (done_o)
    );

    smax_cmp u_cmp (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start_i),
        .step_i  (step),
        .in_b    (bit_i),
        .ref_b   (ref_b),
        .win_o   (win)
    );

    smax_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (start_i),
        .step_i     (step),
        .win_i      (win),
        .in_b       (bit_i),
        .word_idx_i (word_idx),
        .ref_b_o    (ref_b),
        .max_o      (max_o),
        .idx_o      (idx_o)
    );

endmodule

// File: rtl/smax_chk.sv
module smax_chk #(
    parameter int WORD_W    = 8,
    parameter int NUM_WORDS = 16,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              bit_vld_i,
    input logic [WORD_W-1:0] max_o,
    input logic [IDX_W-1:0]  idx_o,
    input logic              done_o
);

    assert_clear_on_start_R1: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (max_o == '0 && idx_o == '0 && !done_o));

    assert_done_rises_on_bit_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(bit_vld_i) && !$past(start_i)));

    assert_done_falls_on_start_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(done_o) |-> $past(start_i));

    assert_hold_after_done_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> ($stable(max_o) && $stable(idx_o) && done_o));

    assert_idle_no_index_change_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(idx_o) |-> ($past(bit_vld_i) || $past(start_i)));

endmodule

bind serial_max_tracker smax_chk #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .bit_vld_i (bit_vld_i),
    .max_o     (max_o),
    .idx_o     (idx_o),
    .done_o    (done_o)
);

// File: tb/test_serial_max_tracker.sv
module test_serial_max_tracker;

    localparam int W  = 8;
    localparam int N  = 16;
    localparam int IW = 4;
    localparam int NV = 6;

    // Stimulus runs and hand-computed results
    localparam logic [7:0] TBL_W [NV][N] = '{
        '{8'h10,8'h20,8'h30,8'h40,8'h50,8'h60,8'h70,8'h80,8'h90,8'hA0,8'hB0,8'hC0,8'hD0,8'hE0,8'hF0,8'hFF},
        '{8'hFF,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
        '{8'h05,8'h7F,8'h80,8'h13,8'h80,8'h22,8'h01,8'h80,8'h7E,8'h00,8'h3C,8'h80,8'h11,8'h12,8'h13,8'h14},
        '{8'h81,8'h82,8'h83,8'h84,8'h85,8'h86,8'h87,8'h88,8'h88,8'h87,8'h86,8'h85,8'h84,8'h83,8'h82,8'h81},
        '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
        '{8'h5A,8'h5B,8'h5A,8'h5C,8'h5C,8'h5B,8'h0F,8'hF0,8'hEF,8'hF1,8'hF0,8'hE0,8'hF1,8'h70,8'h7F,8'h01}
    };
    localparam logic [7:0]    TBL_MAX [NV] = '{8'hFF, 8'hFF, 8'h80, 8'h88, 8'h00, 8'hF1};
    localparam logic [IW-1:0] TBL_IDX [NV] = '{4'd15, 4'd0, 4'd2, 4'd7, 4'd0, 4'd9};

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic          bit_i;
    logic          bit_vld_i;
    logic [W-1:0]  max_o;
    logic [IW-1:0] idx_o;
    logic          done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    serial_max_tracker #(.WORD_W(W), .NUM_WORDS(N)) i_serial_max_tracker (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .bit_i     (bit_i),
        .bit_vld_i (bit_vld_i),
        .max_o     (max_o),
        .idx_o     (idx_o),
        .done_o    (done_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks are entered at a falling edge and return at a falling edge
    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        bit_vld_i = 1'b1;
        bit_i     = b;
        @(negedge clk);
        bit_vld_i = 1'b0;
    endtask

    // With gaps, an idle clock carrying the inverted bit precedes every third bit (R8)
    task automatic send_word(input logic [7:0] w, input bit gaps);
        for (int k = W - 1; k >= 0; k--) begin
            if (gaps && (k % 3 == 0)) begin
                bit_vld_i = 1'b0;
                bit_i     = ~w[k];
                @(negedge clk);
            end
            send_bit(w[k]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        string rq;
        rst = 1'b1; start_i = 1'b0; bit_i = 1'b0; bit_vld_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check("R11 max after reset", max_o, 0);
        check("R11 idx after reset", idx_o, 0);
        check("R11 done after reset", done_o, 0);

        // R11: a full run of bits with no start is ignored
        for (int w = 0; w < N; w++) send_word(8'hFF, 1'b0);
        @(negedge clk);
        check("R11 done without start", done_o, 0);
        check("R11 max without start", max_o, 0);

        // Table-driven runs
        for (int v = 0; v < NV; v++) begin
            bit g;
            g = (v % 2 == 1);
            pulse_start();
            check("R1 max cleared", max_o, 0);
            check("R1 idx cleared", idx_o, 0);
            check("R1 done cleared", done_o, 0);
            for (int w = 0; w < N - 1; w++) send_word(TBL_W[v][w], g);
            for (int k = W - 1; k >= 1; k--) send_bit(TBL_W[v][N-1][k]);
            check("R7 done low before last bit", done_o, 0);
            send_bit(TBL_W[v][N-1][0]);
            check("R7 done after last bit", done_o, 1);
            if (v == 2 || v == 3) rq = "R5 tie";
            else if (v == 4)      rq = "R6 all zero";
            else if (g)           rq = "R8 gapped R3";
            else                  rq = "R2 R3";
            check({rq, " max"}, max_o, TBL_MAX[v]);
            check({rq, " R4 idx"}, idx_o, 32'(TBL_IDX[v]));
        end

        // R9: bits after done are ignored
        send_word(8'hFF, 1'b0);
        send_word(8'hFE, 1'b1);
        @(negedge clk);
        check("R9 max held", max_o, 8'hF1);
        check("R9 idx held", idx_o, 9);
        check("R9 done held", done_o, 1);

        // R10: restart in mid-run
        pulse_start();
        send_word(8'h00, 1'b0);
        send_word(8'hFF, 1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        pulse_start();
        for (int w = 0; w < N; w++) send_word(8'h01, 1'b0);
        check("R10 done after restart", done_o, 1);
        check("R10 max after restart", max_o, 8'h01);
        check("R10 idx after restart", idx_o, 0);

        // R11: reset in the middle of a run leaves no run open
        pulse_start();
        send_word(8'h77, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int w = 0; w < N; w++) send_word(8'h33, 1'b0);
        check("R11 done after mid-run reset", done_o, 0);
        check("R11 max after mid-run reset", max_o, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule